// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a host bridge's register side and its configuration aperture. A configuration request names a bus, a device, a function, a register offset, an access size of 1, 2 or 4 bytes, and a direction. The block checks that the request is legal. It then works out two values: a window-select value for the aperture's upper address bits, and the 32-bit outbound address. It carries out the access on a simple 32-bit read/write port whose responder may flag an error. Type 0 requests for the local bus place a one-hot device select bit. That bit lands partly in the window value and partly in the address.

Reads return the addressed byte lanes, right-aligned. Byte and half-word writes take two bus accesses: the block fetches the dword, replaces only the addressed lanes and writes the dword back. A full-dword write goes straight out. When a bus-side expansion-card mode is set, only device 0 is reachable. A request that fails any check completes at once with an error and touches nothing on the bus.

The controller is a five-state machine:
- `ST_IDLE` accepts a request.
- `ST_CHECK` validates it.
- `ST_RD` holds the dword fetch.
- `ST_WR` holds the store.
- `ST_DONE` raises the completion pulse.

Its transitions are:
- accept (`ST_IDLE`→`ST_CHECK`).
- reject (`ST_CHECK`→`ST_DONE`).
- fetch (`ST_CHECK`→`ST_RD`).
- direct store (`ST_CHECK`→`ST_WR`), for full-dword writes.
- fetch fail (`ST_RD`→`ST_DONE`), on a bus error.
- read return (`ST_RD`→`ST_DONE`).
- merge (`ST_RD`→`ST_WR`), for sub-word writes.
- store done (`ST_WR`→`ST_DONE`).
- release (`ST_DONE`→`ST_IDLE`).

Top module: `pci_cfg_xlate`

## Requirements
- R1: For bus 0 (Type 0), a select bit is set at position 16+device, where device is at most 15. Bits at or above WIN_SPLIT (default 26) of that select bit go to the window value, which is ORed with T0_CODE (default 0x2). Bits below WIN_SPLIT go to the address, which also carries CFG_BASE (default 0x0C000000), the function in bits [10:8] and offset[7:2] in bits [7:2].
- R2: For any nonzero bus (Type 1), the window value is T1_CODE (default 0x3). The address is CFG_BASE with the bus in bits [23:16], the device in [15:11], the function in [10:8] and offset[7:2] in [7:2].
- R3: On bus 0, a device number of 16 or more is rejected.
- R4: With cardbus_mode set, any device number other than 0 is rejected, on any bus.
- R5: An access size (req_size) other than 1, 2 or 4 is rejected.
- R6: An access where offset[1:0] plus the size exceeds 4 is rejected. This includes a 4-byte access at a non-zero byte offset.
- R7: A read returns the fetched dword shifted right by 8×offset[1:0] and cut to the access size, with zero upper bits.
- R8: A 1- or 2-byte write fetches the dword, then stores it back with only the addressed 8- or 16-bit lane replaced by the low bits of req_wdata.
- R9: A 4-byte write makes a single store of req_wdata and no fetch.
- R10: A bus error on any access ends the request with err=1 and rdata=0xFFFFFFFF. A fetch error issues no store.
- R11: req_ready is high only in ST_IDLE. done is a one-cycle pulse. A rejected request finishes with err=1, rdata=0 and no bus access.
- R12: bus_req stays high, with a stable address and direction, until bus_ack. bus_addr is always dword aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| cardbus_mode | input | 1 | Only device 0 reachable |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completed request failed |
| rdata | output | 32 | Read result, right-aligned |
| bus_req | output | 1 | Downstream access request |
| bus_we | output | 1 | Downstream access is a store |
| bus_addr | output | 32 | Outbound aperture address |
| bus_win | output | 32 | Window-select value |
| bus_wdata | output | 32 | Store data |
| bus_rdata | input | 32 | Fetched dword |
| bus_ack | input | 1 | Access finished |
| bus_err | input | 1 | Access failed, valid with bus_ack |

## Verification
The hardest case to reach is the sub-word write. It is the only path that passes through both ST_RD and ST_WR. It is also the only case where the stored value depends both on the fetched dword and on the lane position. The bench's bus responder returns a chosen dword for each vector and records every fetch and store. So the merged store data and the number of accesses can be compared for byte and half-word lanes at several offsets. Failures in the middle of a write are reached by making the responder flag an error on the fetch, which must suppress the store.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD,
        ST_WR,
        ST_DONE
    } xl_state_e;

    localparam int unsigned DW = 32;
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

endpackage

// File: rtl/xl_addr_gen.sv
module xl_addr_gen #(
    parameter int unsigned BUS_W     = 8,
    parameter int unsigned DEV_W     = 5,
    parameter int unsigned FUNC_W    = 3,
    parameter int unsigned OFF_W     = 8,
    parameter int unsigned SLOT_MAX  = 16,
    parameter int unsigned WIN_SPLIT = 26,
    parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
    parameter logic [31:0] T0_CODE   = 32'h0000_0002,
    parameter logic [31:0] T1_CODE   = 32'h0000_0003
) (
    input  logic [BUS_W-1:0]  bus_no,
    input  logic [DEV_W-1:0]  dev_no,
    input  logic [FUNC_W-1:0] func_no,
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        size,
    input  logic              cb_mode,
    output logic              legal,
    output logic [31:0]       addr,
    output logic [31:0]       win
);
    localparam logic [31:0] WIN_MASK = ~((32'd1 << WIN_SPLIT) - 32'd1);
    localparam int unsigned SH_W     = DEV_W + 1;
    localparam int unsigned IDSEL_LO = 16;

    logic        size_ok;
    logic        crosses;
    logic        slot_bad;
    logic        cb_bad;
    logic [3:0]  span_end;
    logic [31:0] idsel;
    logic [31:0] dw_off;

    always_comb begin
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        span_end = {2'b00, offset[1:0]} + {1'b0, size};
        crosses  = span_end > 4'd4;
        slot_bad = (bus_no == '0) && (32'(dev_no) >= SLOT_MAX);
        cb_bad   = cb_mode && (dev_no != '0);
        legal    = size_ok && !crosses && !slot_bad && !cb_bad;

        idsel    = 32'd1 << ({1'b0, dev_no} + SH_W'(IDSEL_LO));
        dw_off   = {24'd0, offset[7:2], 2'b00};

        if (bus_no == '0) begin
            win  = T0_CODE | (idsel & WIN_MASK);
            addr = CFG_BASE | (idsel & ~WIN_MASK)
                 | (32'(func_no) << 8) | dw_off;
        end else begin
            win  = T1_CODE;
            addr = CFG_BASE | (32'(bus_no) << 16) | (32'(dev_no) << 11)
                 | (32'(func_no) << 8) | dw_off;
        end
    end
endmodule

// File: rtl/xl_lane_unit.sv
module xl_lane_unit (
    input  logic [31:0] fetched,
    input  logic [31:0] new_data,
    input  logic [1:0]  byte_sel,
    input  logic [2:0]  size,
    output logic [31:0] aligned,
    output logic [31:0] merged
);
    logic [4:0]  shamt;
    logic [31:0] shifted;
    logic [31:0] lane_mask;

    always_comb begin
        shamt   = {byte_sel, 3'b000};
        shifted = fetched >> shamt;
        unique case (size)
            3'd1:    aligned = {24'd0, shifted[7:0]};
            3'd2:    aligned = {16'd0, shifted[15:0]};
            default: aligned = shifted;
        endcase

        unique case (size)
            3'd1:    lane_mask = 32'h0000_00FF << shamt;
            3'd2:    lane_mask = 32'h0000_FFFF << shamt;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
        merged = (fetched & ~lane_mask) | ((new_data << shamt) & lane_mask);
    end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
    import pci_xlate_pkg::*;
#(
    parameter int unsigned BUS_W     = 8,
    parameter int unsigned DEV_W     = 5,
    parameter int unsigned FUNC_W    = 3,
    parameter int unsigned OFF_W     = 8,
    parameter int unsigned SLOT_MAX  = 16,
    parameter int unsigned WIN_SPLIT = 26,
    parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
    parameter logic [31:0] T0_CODE   = 32'h0000_0002,
    parameter logic [31:0] T1_CODE   = 32'h0000_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              cardbus_mode,
    output logic              done,
    output logic              err,
    output logic [31:0]       rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_win,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    xl_state_e st, st_nx;

    logic              q_write;
    logic [BUS_W-1:0]  q_bus;
    logic [DEV_W-1:0]  q_dev;
    logic [FUNC_W-1:0] q_func;
    logic [OFF_W-1:0]  q_off;
    logic [2:0]        q_size;
    logic [31:0]       q_wdata;
    logic              q_cb;
    logic [31:0]       store_q;
    logic [31:0]       rdata_q;
    logic              err_q;

    logic              legal;
    logic [31:0]       calc_addr;
    logic [31:0]       calc_win;
    logic [31:0]       aligned;
    logic [31:0]       merged;

    xl_addr_gen #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W),
        .SLOT_MAX(SLOT_MAX), .WIN_SPLIT(WIN_SPLIT), .CFG_BASE(CFG_BASE),
        .T0_CODE(T0_CODE), .T1_CODE(T1_CODE)
    ) i_addr (
        .bus_no (q_bus),
        .dev_no (q_dev),
        .func_no(q_func),
        .offset (q_off),
        .size   (q_size),
        .cb_mode(q_cb),
        .legal  (legal),
        .addr   (calc_addr),
        .win    (calc_win)
    );

    xl_lane_unit i_lane (
        .fetched (bus_rdata),
        .new_data(q_wdata),
        .byte_sel(q_off[1:0]),
        .size    (q_size),
        .aligned (aligned),
        .merged  (merged)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nx = ST_CHECK;
            ST_CHECK: begin
                if (!legal)                          st_nx = ST_DONE;
                else if (q_write && q_size == 3'd4)  st_nx = ST_WR;
                else                                 st_nx = ST_RD;
            end
            ST_RD: begin
                if (bus_ack) begin
                    if (bus_err)      st_nx = ST_DONE;
                    else if (q_write) st_nx = ST_WR;
                    else              st_nx = ST_DONE;
                end
            end
            ST_WR:    if (bus_ack) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_bus   <= '0;
            q_dev   <= '0;
            q_func  <= '0;
            q_off   <= '0;
            q_size  <= '0;
            q_wdata <= '0;
            q_cb    <= 1'b0;
            store_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write <= req_write;
                        q_bus   <= req_bus;
                        q_dev   <= req_dev;
                        q_func  <= req_func;
                        q_off   <= req_off;
                        q_size  <= req_size;
                        q_wdata <= req_wdata;
                        q_cb    <= cardbus_mode;
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                    end
                end
                ST_CHECK: begin
                    if (!legal) err_q <= 1'b1;
                    store_q <= q_wdata;
                end
                ST_RD: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            err_q   <= 1'b1;
                            rdata_q <= ALL_ONES;
                        end else if (q_write) begin
                            store_q <= merged;
                        end else begin
                            rdata_q <= aligned;
                        end
                    end
                end
                ST_WR: begin
                    if (bus_ack && bus_err) begin
                        err_q   <= 1'b1;
                        rdata_q <= ALL_ONES;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (st == ST_IDLE);
        done      = (st == ST_DONE);
        bus_req   = (st == ST_RD) || (st == ST_WR);
        bus_we    = (st == ST_WR);
        bus_addr  = calc_addr;
        bus_win   = calc_win;
        bus_wdata = store_q;
        rdata     = rdata_q;
        err       = err_q;
    end
endmodule

// File: rtl/xl_checker.sv
module xl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        done,
    input logic        err,
    input logic [31:0] rdata,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_win,
    input logic        bus_ack,
    input logic        bus_err
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || done) |-> !req_ready); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R12

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00)); // R12

    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_win[1:0] == 2'b10) |-> $onehot0(bus_win[31:2])); // R1

    AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(bus_ack && bus_err)) |-> (err && rdata == 32'hFFFF_FFFF)); // R10

    AST_NO_STORE_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_err && !bus_we) |=> !bus_req); // R10
endmodule

bind pci_cfg_xlate xl_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .done     (done),
    .err      (err),
    .rdata    (rdata),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_win  (bus_win),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err)
);

// File: tb/test_pci_cfg_xlate.sv
module test_pci_cfg_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic        we;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [7:0]  off;
        logic [2:0]  size;
        logic [31:0] wd;
        logic        cb;
        logic [31:0] rv;
        logic        inj;
        logic        xerr;
        logic [31:0] xaddr;
        logic [31:0] xwin;
        logic [31:0] xrd;
        logic [31:0] xwd;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        // R1 type0 dword read, select bit 18
        '{1'b0, 8'd0, 5'd2, 3'd1, 8'h10, 3'd4, 32'h0, 1'b0, 32'hDEADBEEF, 1'b0, 1'b0,
          32'h0C04_0110, 32'h0000_0002, 32'hDEADBEEF, 32'h0, 2'd1, 2'd0, 4'd1},
        // R7 half-word read, select bit 28 in window
        '{1'b0, 8'd0, 5'd12, 3'd0, 8'h06, 3'd2, 32'h0, 1'b0, 32'h12345678, 1'b0, 1'b0,
          32'h0C00_0004, 32'h1000_0002, 32'h0000_1234, 32'h0, 2'd1, 2'd0, 4'd7},
        // R7 byte read, top lane
        '{1'b0, 8'd0, 5'd0, 3'd7, 8'h0B, 3'd1, 32'h0, 1'b0, 32'hA1B2C3D4, 1'b0, 1'b0,
          32'h0C01_0708, 32'h0000_0002, 32'h0000_00A1, 32'h0, 2'd1, 2'd0, 4'd7},
        // R2 type1 read
        '{1'b0, 8'd5, 5'd31, 3'd3, 8'hFC, 3'd4, 32'h0, 1'b0, 32'h0BADF00D, 1'b0, 1'b0,
          32'h0C05_FBFC, 32'h0000_0003, 32'h0BADF00D, 32'h0, 2'd1, 2'd0, 4'd2},
        // R8 byte write lane 1
        '{1'b1, 8'd0, 5'd1, 3'd0, 8'h0D, 3'd1, 32'hFFFF_FF77, 1'b0, 32'h11223344, 1'b0, 1'b0,
          32'h0C02_000C, 32'h0000_0002, 32'h0, 32'h11227744, 2'd1, 2'd1, 4'd8},
        // R8 half-word write upper lane, type1
        '{1'b1, 8'd2, 5'd4, 3'd1, 8'h42, 3'd2, 32'h0000_BEEF, 1'b0, 32'hAAAA5555, 1'b0, 1'b0,
          32'h0C02_2140, 32'h0000_0003, 32'h0, 32'hBEEF5555, 2'd1, 2'd1, 4'd8},
        // R9 full write, select bit 31
        '{1'b1, 8'd0, 5'd15, 3'd2, 8'h20, 3'd4, 32'hCAFEF00D, 1'b0, 32'h0, 1'b0, 1'b0,
          32'h0C00_0220, 32'h8000_0002, 32'h0, 32'hCAFEF00D, 2'd0, 2'd1, 4'd9},
        // R10 read with bus error
        '{1'b0, 8'd0, 5'd3, 3'd0, 8'h00, 3'd4, 32'h0, 1'b0, 32'h1234, 1'b1, 1'b1,
          32'h0C08_0000, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0, 2'd1, 2'd0, 4'd10},
        // R3 device 16 on bus 0
        '{1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1,
          32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 4'd3},
        // R5 size 3
        '{1'b0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd3, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1,
          32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 4'd5},
        // R6 half-word at offset 3
        '{1'b1, 8'd0, 5'd1, 3'd0, 8'h03, 3'd2, 32'h1, 1'b0, 32'h0, 1'b0, 1'b1,
          32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 4'd6},
        // R4 cardbus, device 1
        '{1'b0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 32'h0, 1'b1, 32'h0, 1'b0, 1'b1,
          32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 4'd4},
        // R4 cardbus, device 0 allowed
        '{1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0, 1'b1, 32'h5, 1'b0, 1'b0,
          32'h0C01_0000, 32'h0000_0002, 32'h5, 32'h0, 2'd1, 2'd0, 4'd4},
        // R10 sub-word write, fetch fails, no store
        '{1'b1, 8'd0, 5'd0, 3'd0, 8'h00, 3'd1, 32'h55, 1'b0, 32'h0, 1'b1, 1'b1,
          32'h0C01_0000, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0, 2'd1, 2'd0, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        cardbus_mode = 1'b0;
    logic        done;
    logic        err;
    logic [31:0] rdata;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_win;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack;
    logic        bus_err;
    logic        inj = 1'b0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] cap_addr = '0;
    logic [31:0] cap_win = '0;
    logic [31:0] cap_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_xlate i_pci_cfg_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .cardbus_mode(cardbus_mode), .done(done), .err(err), .rdata(rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_win(bus_win), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // bus responder: acknowledges one cycle after a request, records accesses
    logic ack_q;
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= bus_req && !ack_q;
    end
    assign bus_ack = ack_q;
    assign bus_err = ack_q && inj;

    always_ff @(posedge clk) begin
        if (bus_req && bus_ack) begin
            cap_addr <= bus_addr;
            cap_win  <= bus_win;
            if (bus_we) begin
                wr_cnt    <= wr_cnt + 1;
                cap_wdata <= bus_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int r0, w0, n;
        string tag;
        tag = $sformatf("R%0d v%0d", v.req, idx);
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_write = v.we; req_bus = v.bus; req_dev = v.dev; req_func = v.fn;
        req_off = v.off; req_size = v.size; req_wdata = v.wd;
        cardbus_mode = v.cb; bus_rdata = v.rv; inj = v.inj;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(tag, "done", 32'(done), 32'd1);
        chk(tag, "err", 32'(err), 32'(v.xerr));
        chk(tag, "rdata", rdata, v.xrd);
        chk(tag, "fetches", 32'(rd_cnt - r0), 32'(v.nrd));
        chk(tag, "stores", 32'(wr_cnt - w0), 32'(v.nwr));
        if (v.nrd + v.nwr != 0) begin
            chk(tag, "addr", cap_addr, v.xaddr);
            chk(tag, "win", cap_win, v.xwin);
        end
        if (v.nwr != 0) chk(tag, "store data", cap_wdata, v.xwd);
        // R11 done lasts one cycle, then idle again
        @(negedge clk);
        chk(tag, "done width R11", 32'(done), 32'd0);
        chk(tag, "ready after R11", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "reset ready", 32'(req_ready), 32'd1);
        chk("R11", "reset done", 32'(done), 32'd0);
        chk("R12", "reset bus_req", 32'(bus_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

        // R11 ready drops while busy with a request
        @(negedge clk);
        req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd1; req_func = 3'd0;
        req_off = 8'h00; req_size = 3'd4; cardbus_mode = 1'b0; inj = 1'b0;
        bus_rdata = 32'h77;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "busy ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R12", "bus_req during fetch", 32'(bus_req), 32'd1);
        repeat (4) @(negedge clk);
        chk("R7", "directed read", rdata, 32'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule